// File: doc/BRIEF.md
# SMBus Host Block-Transfer Controller

This block is the register front end and transaction sequencer of an SMBus host that moves blocks of up to 32 bytes to or from a target device. Software programs a target address byte, a command byte and, for writes, a byte count through a byte-wide register port. It fills a 32-entry data buffer through a single auto-incrementing data port and then sets a go bit in the control register. Reading the control register rewinds the buffer pointer, so a transfer is prepared or collected with one control read followed by a run of data-port accesses.

Once started, the sequencer expresses the whole transaction as byte-level primitives on a request/acknowledge port: bus start, byte send, byte receive with host ACK or NACK, and bus stop. A separate bit-level engine serves those primitives. Busy, success and two error causes are visible in the status register, and the completion and error flags are cleared by writing ones to them.

Top module: `smb_blk_host`

## Requirements
- R1: After reset, every register reads 0x00: status (offset 0x0), control (0x2), command (0x3), target address (0x4), count (0x5), spare data (0x6) and mode (0xD). `reg_rdata` always shows the register selected by `reg_addr`.
- R2: A read strobe at the control offset sets the buffer pointer to entry 0. Each read or write strobe at the data port (0x7) accesses the entry under the pointer and then advances the pointer, so bytes read back in the order they were written.
- R3: Block write. Target address bit 0 = 0. The primitive sequence is start, send {addr[7:1],0}, send command, send count, send `count` buffer bytes from entry 0 upward, then stop. Primitive op codes: 0 start, 1 send, 2 receive, 3 stop.
- R4: Block read. Target address bit 0 = 1. The sequence is start, send {addr[7:1],0}, send command, start, send {addr[7:1],1}, then receive the count byte. The count byte is stored in the count register (0x5). That many data bytes are then received into buffer entries 0 upward, and a stop ends the transaction.
- R5: In a block read, the host ACKs the count byte and every data byte except the last one. The last data byte is received with `prim_nack` = 1.
- R6: Status bit 0 (busy) is 1 from the cycle after an accepted go write until the stop primitive is acknowledged. A go write (control bit 6) made while busy is ignored. Control bit 6 always reads 0.
- R7: If the target does not acknowledge any sent byte (`prim_rxack` = 0), the host issues a stop next and sets status bit 2. It issues no further sends.
- R8: A transaction that finishes without error sets status bit 1 in the same cycle that busy falls.
- R9: A count of 0 or above 32 sets status bit 3. For a write, the count is checked before any bus activity and no primitive is issued. For a read, the count is checked after the count byte is received, and the host then issues only a stop.
- R10: A go write is rejected with status bit 3 and no primitives unless it selects protocol 3'b101 in control bits 4:2 and mode register bit 1 (32-byte buffer enable) is set.
- R11: Writing the status register clears each of bits 3:1 that is written as 1 and leaves the others. A flag set by a completion in the same cycle as a clearing write stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; side effects only at control and data-port offsets |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Contents of the register at `reg_addr` |
| prim_req | output | 1 | A primitive is outstanding |
| prim_op | output | 2 | Primitive: 0 start, 1 send, 2 receive, 3 stop |
| prim_wbyte | output | 8 | Byte to send |
| prim_nack | output | 1 | For a receive: host answers NACK |
| prim_ack | input | 1 | Primitive finished this cycle |
| prim_rxack | input | 1 | For a send: target acknowledged the byte |
| prim_rbyte | input | 8 | For a receive: byte received |

## Verification
Two events can fall in the same cycle: a transaction completes and sets a status flag, and software writes ones to the status register to clear that same flag. The bench holds a clearing write on the status offset continuously while a transfer runs. It then looks at the first cycle in which busy reads 0. Bit 1 must read set there, because the set must win over the simultaneous clear. A second, plain clearing write must then remove it. A buffer port access that coincides with the sequencer filling the buffer is not possible, because host writes to the data port are dropped while the block is busy.

// File: rtl/smb_blk_pkg.sv
package smb_blk_pkg;

    localparam int BUF_DEPTH = 32;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_SEND  = 2'd1,
        OP_RECV  = 2'd2,
        OP_STOP  = 2'd3
    } prim_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_ADDRW, S_CMD, S_WCNT, S_WDATA,
        S_RSTART, S_ADDRR, S_RCNT, S_RDATA, S_STOP, S_FAIL
    } seq_state_e;

    // register byte offsets
    localparam logic [3:0] OFS_STAT  = 4'h0;
    localparam logic [3:0] OFS_CTRL  = 4'h2;
    localparam logic [3:0] OFS_CMD   = 4'h3;
    localparam logic [3:0] OFS_TADDR = 4'h4;
    localparam logic [3:0] OFS_CNT   = 4'h5;
    localparam logic [3:0] OFS_SPARE = 4'h6;
    localparam logic [3:0] OFS_PORT  = 4'h7;
    localparam logic [3:0] OFS_MODE  = 4'hD;

    localparam logic [2:0] PROTO_BLOCK  = 3'b101;
    localparam int         CTRL_GO_BIT  = 6;
    localparam int         MODE_WIDE_BIT = 1;

    // field order matches status bits 3..1
    typedef struct packed {
        logic bad;
        logic dev;
        logic ok;
    } fin_t;

    function automatic logic count_ok(input logic [7:0] c, input int depth);
        return (c != 8'd0) && (int'(c) <= depth);
    endfunction

endpackage

// File: rtl/smb_blk_buf.sv
module smb_blk_buf
    import smb_blk_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          h_rewind,
    input  logic          h_step,
    input  logic          h_we,
    input  logic [7:0]    h_wdata,
    output logic [7:0]    h_rdata,
    input  logic          s_we,
    input  logic [AW-1:0] s_addr,
    input  logic [7:0]    s_wdata,
    output logic [7:0]    s_rdata
);

    logic [AW-1:0] idx;
    logic [7:0]    mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (h_rewind)
            idx <= '0;
        else if (h_step)
            idx <= (idx == AW'(DEPTH - 1)) ? '0 : idx + AW'(1);
    end

    // sequencer fills take priority over the host port
    always_ff @(posedge clk) begin
        if (s_we)
            mem[s_addr] <= s_wdata;
        else if (h_we)
            mem[idx] <= h_wdata;
    end

    assign h_rdata = mem[idx];
    assign s_rdata = mem[s_addr];

    p_rewind_r2: assert property (@(posedge clk) disable iff (rst)
        h_rewind |=> (idx == '0));

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (h_step && !h_rewind && idx == '0) |=> (idx == AW'(1)));

endmodule

// File: rtl/smb_blk_seq.sv
module smb_blk_seq
    import smb_blk_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          mode_ok,
    input  logic [6:0]    taddr7,
    input  logic          rd_dir,
    input  logic [7:0]    cmd,
    input  logic [7:0]    wcnt,
    output logic          busy,
    output fin_t          fin,
    output logic          prim_req,
    output logic [1:0]    prim_op,
    output logic [7:0]    prim_wbyte,
    output logic          prim_nack,
    input  logic          prim_ack,
    input  logic          prim_rxack,
    input  logic [7:0]    prim_rbyte,
    output logic [AW-1:0] buf_addr,
    input  logic [7:0]    buf_rdata,
    output logic          buf_we,
    output logic          cnt_we
);

    seq_state_e    state;
    prim_op_e      op;
    logic [6:0]    addr_q;
    logic [7:0]    cmd_q;
    logic [7:0]    cnt_q;
    logic [AW-1:0] sidx;
    fin_t          res_q;
    logic          last;
    logic          is_send;

    assign last    = (8'(sidx) == cnt_q - 8'd1);
    assign is_send = (state == S_ADDRW) || (state == S_CMD) || (state == S_WCNT) ||
                     (state == S_WDATA) || (state == S_ADDRR);

    always_comb begin
        prim_req   = 1'b1;
        op         = OP_SEND;
        prim_wbyte = 8'h00;
        prim_nack  = 1'b0;
        case (state)
            S_START, S_RSTART: op = OP_START;
            S_ADDRW:           prim_wbyte = {addr_q, 1'b0};
            S_CMD:             prim_wbyte = cmd_q;
            S_WCNT:            prim_wbyte = cnt_q;
            S_WDATA:           prim_wbyte = buf_rdata;
            S_ADDRR:           prim_wbyte = {addr_q, 1'b1};
            S_RCNT:            op = OP_RECV;
            S_RDATA: begin
                op        = OP_RECV;
                prim_nack = last;
            end
            S_STOP:            op = OP_STOP;
            default: begin
                prim_req = 1'b0;
                op       = OP_START;
            end
        endcase
    end

    assign prim_op  = op;
    assign busy     = (state != S_IDLE);
    assign buf_addr = sidx;
    assign buf_we   = (state == S_RDATA) && prim_ack;
    assign cnt_we   = (state == S_RCNT) && prim_ack;

    always_comb begin
        fin = '0;
        if (state == S_STOP && prim_ack)
            fin = res_q;
        if (state == S_FAIL)
            fin.bad = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            addr_q <= '0;
            cmd_q  <= '0;
            cnt_q  <= '0;
            sidx   <= '0;
            res_q  <= '0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (go) begin
                        addr_q <= taddr7;
                        cmd_q  <= cmd;
                        cnt_q  <= wcnt;
                        res_q  <= '0;
                        if (!mode_ok || (!rd_dir && !count_ok(wcnt, DEPTH)))
                            state <= S_FAIL;
                        else
                            state <= S_START;
                    end
                end
                S_FAIL: state <= S_IDLE;
                default: begin
                    if (prim_ack) begin
                        if (is_send && !prim_rxack) begin
                            res_q.dev <= 1'b1;
                            state     <= S_STOP;
                        end else begin
                            case (state)
                                S_START:  state <= S_ADDRW;
                                S_ADDRW:  state <= S_CMD;
                                S_CMD:    state <= rd_dir_q() ? S_RSTART : S_WCNT;
                                S_WCNT: begin
                                    sidx  <= '0;
                                    state <= S_WDATA;
                                end
                                S_RSTART: state <= S_ADDRR;
                                S_ADDRR:  state <= S_RCNT;
                                S_RCNT: begin
                                    cnt_q <= prim_rbyte;
                                    sidx  <= '0;
                                    if (count_ok(prim_rbyte, DEPTH)) begin
                                        state <= S_RDATA;
                                    end else begin
                                        res_q.bad <= 1'b1;
                                        state     <= S_STOP;
                                    end
                                end
                                S_WDATA, S_RDATA: begin
                                    if (last) begin
                                        res_q.ok <= 1'b1;
                                        state    <= S_STOP;
                                    end else begin
                                        sidx <= sidx + AW'(1);
                                    end
                                end
                                default: state <= S_IDLE;
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    logic rd_q;
    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= 1'b0;
        else if (state == S_IDLE && go)
            rd_q <= rd_dir;
    end

    function automatic logic rd_dir_q();
        return rd_q;
    endfunction

    p_stop_after_nack_r7: assert property (@(posedge clk) disable iff (rst)
        (prim_req && prim_ack && prim_op == OP_SEND && !prim_rxack)
        |=> (prim_req && prim_op == OP_STOP));

    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (state == S_WDATA || state == S_RDATA) |-> (cnt_q != 8'd0 && int'(cnt_q) <= DEPTH));

    p_nack_in_data_r5: assert property (@(posedge clk) disable iff (rst)
        (prim_req && prim_op == OP_RECV && prim_nack) |-> (state == S_RDATA));

endmodule

// File: rtl/smb_blk_host.sv
module smb_blk_host
    import smb_blk_pkg::*;
#(
    parameter int DEPTH = BUF_DEPTH,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [3:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       prim_req,
    output logic [1:0] prim_op,
    output logic [7:0] prim_wbyte,
    output logic       prim_nack,
    input  logic       prim_ack,
    input  logic       prim_rxack,
    input  logic [7:0] prim_rbyte
);

    logic [7:0]    ctrl_q, cmd_q, taddr_q, cnt_q, spare_q;
    logic [1:0]    mode_q;
    logic [2:0]    flags_q;
    logic          busy, go, mode_ok, cnt_we, buf_we;
    fin_t          fin;
    logic [AW-1:0] buf_addr;
    logic [7:0]    buf_rdata, port_rdata;
    logic [2:0]    clr;

    function automatic logic hit_wr(input logic [3:0] ofs);
        return reg_wr && (reg_addr == ofs);
    endfunction

    assign go      = hit_wr(OFS_CTRL) && reg_wdata[CTRL_GO_BIT] && !busy;
    assign mode_ok = (reg_wdata[4:2] == PROTO_BLOCK) && mode_q[MODE_WIDE_BIT];
    assign clr     = hit_wr(OFS_STAT) ? reg_wdata[3:1] : 3'b000;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            cmd_q   <= '0;
            taddr_q <= '0;
            cnt_q   <= '0;
            spare_q <= '0;
            mode_q  <= '0;
            flags_q <= '0;
        end else begin
            if (hit_wr(OFS_CTRL))  ctrl_q  <= reg_wdata & ~(8'h01 << CTRL_GO_BIT);
            if (hit_wr(OFS_CMD))   cmd_q   <= reg_wdata;
            if (hit_wr(OFS_TADDR)) taddr_q <= reg_wdata;
            if (hit_wr(OFS_SPARE)) spare_q <= reg_wdata;
            if (hit_wr(OFS_MODE))  mode_q  <= reg_wdata[1:0];
            if (cnt_we)                cnt_q <= prim_rbyte;
            else if (hit_wr(OFS_CNT))  cnt_q <= reg_wdata;
            // a completion in the same cycle wins over a clearing write
            flags_q <= (flags_q & ~clr) | fin;
        end
    end

    always_comb begin
        case (reg_addr)
            OFS_STAT:  reg_rdata = {4'b0000, flags_q, busy};
            OFS_CTRL:  reg_rdata = ctrl_q;
            OFS_CMD:   reg_rdata = cmd_q;
            OFS_TADDR: reg_rdata = taddr_q;
            OFS_CNT:   reg_rdata = cnt_q;
            OFS_SPARE: reg_rdata = spare_q;
            OFS_PORT:  reg_rdata = port_rdata;
            OFS_MODE:  reg_rdata = {6'b000000, mode_q};
            default:   reg_rdata = 8'h00;
        endcase
    end

    smb_blk_buf #(.DEPTH(DEPTH)) i_buf (
        .clk      (clk),
        .rst      (rst),
        .h_rewind (reg_rd && reg_addr == OFS_CTRL),
        .h_step   ((reg_addr == OFS_PORT) && (reg_rd || (reg_wr && !busy))),
        .h_we     (hit_wr(OFS_PORT) && !busy),
        .h_wdata  (reg_wdata),
        .h_rdata  (port_rdata),
        .s_we     (buf_we),
        .s_addr   (buf_addr),
        .s_wdata  (prim_rbyte),
        .s_rdata  (buf_rdata)
    );

    smb_blk_seq #(.DEPTH(DEPTH)) i_seq (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .mode_ok    (mode_ok),
        .taddr7     (taddr_q[7:1]),
        .rd_dir     (taddr_q[0]),
        .cmd        (cmd_q),
        .wcnt       (cnt_q),
        .busy       (busy),
        .fin        (fin),
        .prim_req   (prim_req),
        .prim_op    (prim_op),
        .prim_wbyte (prim_wbyte),
        .prim_nack  (prim_nack),
        .prim_ack   (prim_ack),
        .prim_rxack (prim_rxack),
        .prim_rbyte (prim_rbyte),
        .buf_addr   (buf_addr),
        .buf_rdata  (buf_rdata),
        .buf_we     (buf_we),
        .cnt_we     (cnt_we)
    );

    p_busy_from_go_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(reg_wr && reg_addr == OFS_CTRL && reg_wdata[CTRL_GO_BIT]));

    p_done_flag_r8: assert property (@(posedge clk) disable iff (rst)
        fin.ok |=> flags_q[0]);

    p_dev_flag_r7: assert property (@(posedge clk) disable iff (rst)
        fin.dev |=> flags_q[1]);

endmodule

// File: tb/test_smb_blk_host.sv
module test_smb_blk_host;

    localparam int CLK_PERIOD = 10;
    localparam int LOGSZ = 80;

    localparam logic [3:0] A_STAT = 4'h0, A_CTRL = 4'h2, A_CMD = 4'h3, A_TADDR = 4'h4,
                           A_CNT = 4'h5, A_SPARE = 4'h6, A_PORT = 4'h7, A_MODE = 4'hD;
    localparam logic [1:0] K_START = 2'd0, K_SEND = 2'd1, K_RECV = 2'd2, K_STOP = 2'd3;

    // {rd, addr7, cmd, count, nack_at_send, expected status}
    localparam int NVEC = 12;
    localparam logic [39:0] VEC [NVEC] = '{
        {1'b0, 7'h50, 8'h10, 8'd3,  8'hFF, 8'h02},
        {1'b1, 7'h2C, 8'h05, 8'd4,  8'hFF, 8'h02},
        {1'b0, 7'h11, 8'hA0, 8'd32, 8'hFF, 8'h02},
        {1'b1, 7'h7F, 8'h00, 8'd1,  8'hFF, 8'h02},
        {1'b0, 7'h22, 8'h01, 8'd2,  8'h00, 8'h04},
        {1'b0, 7'h23, 8'h02, 8'd4,  8'h03, 8'h04},
        {1'b1, 7'h24, 8'h03, 8'd2,  8'h02, 8'h04},
        {1'b0, 7'h25, 8'h04, 8'd0,  8'hFF, 8'h08},
        {1'b0, 7'h26, 8'h05, 8'd33, 8'hFF, 8'h08},
        {1'b1, 7'h27, 8'h06, 8'd0,  8'hFF, 8'h08},
        {1'b1, 7'h28, 8'h07, 8'd32, 8'hFF, 8'h02},
        {1'b1, 7'h29, 8'h08, 8'd40, 8'hFF, 8'h08}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       prim_req, prim_nack;
    logic [1:0] prim_op;
    logic [7:0] prim_wbyte;
    logic       prim_ack = 1'b0, prim_rxack = 1'b0;
    logic [7:0] prim_rbyte = 8'h00;

    int errors = 0, checks = 0;
    bit finished = 0;

    logic [10:0] log_q [LOGSZ];
    logic [10:0] exp_q [LOGSZ];
    logic [7:0]  rx_q  [LOGSZ];
    int log_n = 0, exp_n = 0, rx_n = 0, nsend = 0, nack_at = 255;
    int esc = 0;
    bit eab = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    smb_blk_host i_smb_blk_host (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .prim_req(prim_req),
        .prim_op(prim_op), .prim_wbyte(prim_wbyte), .prim_nack(prim_nack),
        .prim_ack(prim_ack), .prim_rxack(prim_rxack), .prim_rbyte(prim_rbyte)
    );

    // target-side responder: answers each primitive, logs what it saw
    initial begin
        forever begin
            @(negedge clk);
            if (prim_ack) begin
                prim_ack = 1'b0;
            end else if (prim_req && !rst) begin
                logic [10:0] e;
                case (prim_op)
                    K_SEND: begin
                        prim_rxack = (nsend != nack_at);
                        e = {K_SEND, 1'b0, prim_wbyte};
                        nsend++;
                    end
                    K_RECV: begin
                        prim_rbyte = rx_q[rx_n];
                        e = {K_RECV, prim_nack, rx_q[rx_n]};
                        if (rx_n < LOGSZ - 1) rx_n++;
                    end
                    default: e = {prim_op, 9'h000};
                endcase
                if (log_n < LOGSZ) begin
                    log_q[log_n] = e;
                    log_n++;
                end
                prim_ack = 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rdr(input logic [3:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 2000; i++) begin
            peek(A_STAT, s);
            if (!s[0]) break;
            @(negedge clk);
        end
    endtask

    task automatic push(input logic [10:0] e);
        if (exp_n < LOGSZ) begin
            exp_q[exp_n] = e;
            exp_n++;
        end
    endtask

    task automatic exp_send(input logic [7:0] b);
        if (!eab) begin
            push({K_SEND, 1'b0, b});
            if (esc == nack_at) eab = 1;
            esc++;
        end
    endtask

    function automatic logic [7:0] dbyte(input int k, input int i);
        return 8'(k * 17 + i + 1);
    endfunction

    task automatic run_vec(input logic [39:0] v, input int k);
        logic       rdb = v[39];
        logic [6:0] a7 = v[38:32];
        logic [7:0] cmd = v[31:24];
        logic [7:0] cnt = v[23:16];
        logic [7:0] exps = v[7:0];
        logic [7:0] t;
        bit         valid = (cnt != 0) && (cnt <= 32);
        bit         ok;
        string      tag;
        int         nk;

        wr(A_STAT, 8'h0E);
        wr(A_TADDR, {a7, rdb});
        wr(A_CMD, cmd);
        if (!rdb) begin
            wr(A_CNT, cnt);
            rdr(A_CTRL, t);
            for (int i = 0; i < ((cnt > 32) ? 32 : int'(cnt)); i++) wr(A_PORT, dbyte(k, i));
        end else begin
            rx_q[0] = cnt;
            for (int i = 1; i < LOGSZ; i++) rx_q[i] = dbyte(k, i - 1);
        end
        log_n = 0; rx_n = 0; nsend = 0; nack_at = int'(v[15:8]);
        wr(A_CTRL, 8'h54);
        wait_idle();

        exp_n = 0; esc = 0; eab = 0;
        if (!rdb) begin
            if (valid) begin
                push({K_START, 9'h0});
                exp_send({a7, 1'b0});
                exp_send(cmd);
                exp_send(cnt);
                for (int i = 0; i < int'(cnt); i++) exp_send(dbyte(k, i));
                push({K_STOP, 9'h0});
            end
        end else begin
            push({K_START, 9'h0});
            exp_send({a7, 1'b0});
            exp_send(cmd);
            if (!eab) push({K_START, 9'h0});
            exp_send({a7, 1'b1});
            if (!eab) begin
                push({K_RECV, 1'b0, cnt});
                if (valid)
                    for (int i = 0; i < int'(cnt); i++)
                        push({K_RECV, (i == int'(cnt) - 1), dbyte(k, i)});
            end
            push({K_STOP, 9'h0});
        end

        tag = (exps == 8'h04) ? "R7" : (exps == 8'h08) ? "R9" : (rdb ? "R4" : "R3");
        ok = (log_n == exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            if (log_q[i] !== exp_q[i]) ok = 0;
        check(ok, tag, log_n, exp_n);

        peek(A_STAT, t);
        check(t == exps, (exps == 8'h02) ? "R8" : tag, t, exps);

        if (rdb && exps != 8'h04) begin
            peek(A_CNT, t);
            check(t == cnt, "R4 count stored", t, cnt);
        end
        if (rdb && exps == 8'h02) begin
            nk = 0;
            for (int i = 0; i < log_n; i++)
                if (log_q[i][10:9] == K_RECV && log_q[i][8]) nk++;
            check(nk == 1 && log_q[log_n - 2][8] == 1'b1, "R5", nk, 1);
            rdr(A_CTRL, t);
            ok = 1;
            for (int i = 0; i < int'(cnt); i++) begin
                rdr(A_PORT, t);
                if (t != dbyte(k, i)) ok = 0;
            end
            check(ok, "R4 buffer fill", ok, 1);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [7:0] t, u;
        for (int i = 0; i < LOGSZ; i++) rx_q[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        peek(A_STAT, t);  check(t == 8'h00, "R1 status", t, 0);
        peek(A_CTRL, t);  check(t == 8'h00, "R1 control", t, 0);
        peek(A_CMD, t);   check(t == 8'h00, "R1 command", t, 0);
        peek(A_TADDR, t); check(t == 8'h00, "R1 address", t, 0);
        peek(A_CNT, t);   check(t == 8'h00, "R1 count", t, 0);
        peek(A_SPARE, t); check(t == 8'h00, "R1 spare", t, 0);
        peek(A_MODE, t);  check(t == 8'h00, "R1 mode", t, 0);

        // R10 start rejected without wide-buffer mode
        log_n = 0;
        wr(A_CNT, 8'd2);
        wr(A_CTRL, 8'h54);
        wait_idle();
        peek(A_STAT, t);
        check(t == 8'h08 && log_n == 0, "R10 mode off", {log_n[7:0], t}, 8'h08);

        // R2 buffer pointer
        wr(A_MODE, 8'h02);
        rdr(A_CTRL, t);
        wr(A_PORT, 8'hA1); wr(A_PORT, 8'hB2); wr(A_PORT, 8'hC3);
        rdr(A_CTRL, t);
        rdr(A_PORT, t); check(t == 8'hA1, "R2 entry0", t, 8'hA1);
        rdr(A_PORT, t); check(t == 8'hB2, "R2 entry1", t, 8'hB2);
        rdr(A_CTRL, t);
        rdr(A_PORT, t); check(t == 8'hA1, "R2 rewind", t, 8'hA1);

        // R10 wrong protocol
        wr(A_STAT, 8'h0E);
        log_n = 0;
        wr(A_CTRL, 8'h4C);
        wait_idle();
        peek(A_STAT, t);
        check(t == 8'h08 && log_n == 0, "R10 protocol", {log_n[7:0], t}, 8'h08);

        // table walk: R3 R4 R5 R7 R8 R9
        for (int k = 0; k < NVEC; k++) run_vec(VEC[k], k);

        // R6 busy and go ignored while busy; go bit self clears
        wr(A_STAT, 8'h0E);
        wr(A_TADDR, 8'hA0); wr(A_CMD, 8'h33); wr(A_CNT, 8'd3);
        rdr(A_CTRL, t);
        for (int i = 0; i < 3; i++) wr(A_PORT, 8'(i));
        log_n = 0; nsend = 0; nack_at = 255;
        wr(A_CTRL, 8'h54);
        peek(A_STAT, t);
        check(t[0] == 1'b1, "R6 busy after go", t[0], 1);
        wr(A_CTRL, 8'h54);
        wait_idle();
        check(log_n == 8, "R6 go while busy ignored", log_n, 8);
        peek(A_CTRL, t);
        check(t == 8'h14, "R6 go bit self clears", t, 8'h14);

        // R11 completion and clearing write in the same cycle
        wr(A_STAT, 8'h0E);
        rdr(A_CTRL, t);
        for (int i = 0; i < 3; i++) wr(A_PORT, 8'(i));
        log_n = 0; nsend = 0;
        wr(A_CTRL, 8'h54);
        reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 8'h02;
        for (int i = 0; i < 500; i++) begin
            @(negedge clk);
            #1;
            if (!reg_rdata[0]) break;
        end
        t = reg_rdata;
        reg_wr = 1'b0;
        check(t == 8'h02, "R11 set wins over clear", t, 8'h02);
        @(negedge clk);
        wr(A_STAT, 8'h02);
        peek(A_STAT, t);
        check(t == 8'h00, "R11 clear", t, 0);

        // R11 partial clear keeps other flags
        run_vec(VEC[4], 4);
        wr(A_STAT, 8'h0A);
        peek(A_STAT, u);
        check(u == 8'h04, "R11 partial clear", u, 8'h04);
        wr(A_STAT, 8'h04);
        peek(A_STAT, u);
        check(u == 8'h00, "R11 clear dev flag", u, 0);

        summary();
    end

endmodule